// File: doc/BRIEF.md
# Pending Interrupt Priority Selector

This block keeps one pending bit for each asynchronous interrupt source of a processor core. Sources raise their bit with a one-cycle set pulse. A message-clear path can drop a bit with a one-cycle clear pulse. Whenever the core polls, the block looks at the pending bits in a fixed priority order and picks at most one source. It reports the source's code with a one-cycle take strobe, and it drops the pending bit of that source unless the source is level-like.

Sources are gated in groups. System reset and machine check are always eligible. The critical external input needs the critical-enable bit of the machine state. Nine further sources need the external-enable bit. A hypervisor decrementer slot exists in the order, but its enable is tied off, so it is never taken and never blocks a lower source.

Source codes, which are also the bit positions in the set and clear vectors and the priority rank (0 is highest): 0 system reset, 1 machine check, 2 hypervisor decrementer, 3 critical external, 4 watchdog, 5 critical doorbell, 6 fixed-interval timer, 7 programmable interval timer, 8 decrementer, 9 external input, 10 doorbell, 11 performance monitor, 12 thermal.

Top module: `irq_prio_sel`

## Requirements
- R1: After reset, take_o is 0, code_o is 0 and no source is pending, so a poll with both enables set takes nothing.
- R2: Source 0 (system reset) outranks everything, and source 1 (machine check) comes next. Both are taken whatever the enable bits are, and both pending bits are cleared when taken.
- R3: Source 3 (critical external) is taken only while crit_en_i is 1. Its pending bit stays set after it is taken.
- R4: Sources 4 to 12 are taken only while ext_en_i is 1, with the lower code winning.
- R5: Source 9 (external input) stays pending after it is taken. Every other source from 4 to 12 is cleared when taken.
- R6: A poll takes at most one source: the eligible pending source with the lowest code.
- R7: Source 2 (hypervisor decrementer) is never taken, and its pending bit does not stop a lower-priority source from being taken.
- R8: When a set pulse for a source coincides with a clear pulse or with that source being taken, the pending bit ends up set.
- R9: A clr_i pulse drops the pending bit, so a later poll does not take that source.
- R10: take_o and code_o are registered and rise in the cycle after the poll. Without a poll, or when nothing eligible is pending, take_o is 0 and code_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_i | input | 1 | Core asks for one interrupt this cycle |
| set_i | input | 13 | Per-source set pulses (bit = source code) |
| clr_i | input | 13 | Per-source clear pulses from the message-clear path |
| crit_en_i | input | 1 | Critical-enable bit of the machine state |
| ext_en_i | input | 1 | External-enable bit of the machine state |
| take_o | output | 1 | One-cycle strobe: a source was taken |
| code_o | output | 4 | Code of the source taken, 0 when take_o is 0 |

## Verification
The bench goes after several corner cases:
- It repolls the two level-like sources. A design that cleared them on take would go silent on the second poll.
- It polls with an enable off while gated sources are pending. A gate wired to the wrong group would take a source early.
- It leaves the hypervisor decrementer pending on its own and then with lower sources pending. A design that let it through would report code 2, and one that let it block would hide the sources below it.
- It sends set and clear, and set and take, in the same cycle. A design where the clear wins would lose the request.
- It checks that every poll yields exactly one code, in rank order. A scan in the wrong direction, or one that does not stop at the first match, would report the wrong source.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;

    localparam int NSRC   = 13;
    localparam int CODE_W = $clog2(NSRC);

    localparam int SRC_SYSRST = 0;
    localparam int SRC_MCHK   = 1;
    localparam int SRC_HVDEC  = 2;
    localparam int SRC_CRIT   = 3;
    localparam int SRC_WDOG   = 4;
    localparam int SRC_EXTIN  = 9;

    typedef enum logic [1:0] {
        GATE_ALWAYS,
        GATE_TIED,
        GATE_CRIT,
        GATE_EXT
    } gate_e;

    typedef struct packed {
        logic              take;
        logic [CODE_W-1:0] code;
    } sel_out_t;

    // enable group a source belongs to
    function automatic gate_e src_gate(int idx);
        if (idx == SRC_SYSRST || idx == SRC_MCHK) return GATE_ALWAYS;
        if (idx == SRC_HVDEC)                     return GATE_TIED;
        if (idx == SRC_CRIT)                      return GATE_CRIT;
        return GATE_EXT;
    endfunction

    // level-like sources keep their pending bit when taken
    function automatic logic src_sticky(int idx);
        return (idx == SRC_CRIT) || (idx == SRC_EXTIN);
    endfunction

endpackage

// File: rtl/irqsel_pending.sv
module irqsel_pending #(
    parameter int N = irqsel_pkg::NSRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] take_clr_i,
    output logic [N-1:0] pend_o
);
    logic [N-1:0] pend_d, pend_q;

    always_comb begin
        // set is applied last so it wins over both clear paths
        pend_d = (pend_q & ~clr_i & ~take_clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;

    for (genvar g = 0; g < N; g++) begin : g_chk
        assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> pend_q[g]);
        assert_clear_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !pend_q[g]);
    end

endmodule

// File: rtl/irqsel_gate.sv
module irqsel_gate #(
    parameter int N = irqsel_pkg::NSRC
) (
    input  logic [N-1:0] pend_i,
    input  logic         crit_en_i,
    input  logic         ext_en_i,
    output logic [N-1:0] elig_o
);
    import irqsel_pkg::*;

    // hypervisor decrementer enable, permanently tied off
    logic hv_dec_en;
    assign hv_dec_en = 1'b0;

    for (genvar g = 0; g < N; g++) begin : g_gate
        if (src_gate(g) == GATE_ALWAYS) begin : g_always
            assign elig_o[g] = pend_i[g];
        end else if (src_gate(g) == GATE_TIED) begin : g_tied
            assign elig_o[g] = pend_i[g] & hv_dec_en;
        end else if (src_gate(g) == GATE_CRIT) begin : g_crit
            assign elig_o[g] = pend_i[g] & crit_en_i;
        end else begin : g_ext
            assign elig_o[g] = pend_i[g] & ext_en_i;
        end
    end

endmodule

// File: rtl/irqsel_pick.sv
module irqsel_pick #(
    parameter int N = irqsel_pkg::NSRC,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] elig_i,
    output logic         found_o,
    output logic [W-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        // scan from the lowest rank upward so the highest rank is written last
        for (int i = N - 1; i >= 0; i--) begin
            if (elig_i[i]) begin
                found_o = 1'b1;
                idx_o   = W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
    import irqsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              poll_i,
    input  logic [NSRC-1:0]   set_i,
    input  logic [NSRC-1:0]   clr_i,
    input  logic              crit_en_i,
    input  logic              ext_en_i,
    output logic              take_o,
    output logic [CODE_W-1:0] code_o
);
    logic [NSRC-1:0]   pend;
    logic [NSRC-1:0]   elig;
    logic [NSRC-1:0]   take_clr;
    logic              found;
    logic [CODE_W-1:0] pick;
    sel_out_t          out_d, out_q;

    irqsel_pending #(.N(NSRC)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (set_i),
        .clr_i      (clr_i),
        .take_clr_i (take_clr),
        .pend_o     (pend)
    );

    irqsel_gate #(.N(NSRC)) u_gate (
        .pend_i    (pend),
        .crit_en_i (crit_en_i),
        .ext_en_i  (ext_en_i),
        .elig_o    (elig)
    );

    irqsel_pick #(.N(NSRC)) u_pick (
        .elig_i  (elig),
        .found_o (found),
        .idx_o   (pick)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_tclr
        if (src_sticky(g)) begin : g_keep
            assign take_clr[g] = 1'b0;
        end else begin : g_drop
            assign take_clr[g] = poll_i & found & (pick == CODE_W'(g));
        end
    end

    always_comb begin
        out_d      = '0;
        out_d.take = poll_i & found;
        if (poll_i && found) out_d.code = pick;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign take_o = out_q.take;
    assign code_o = out_q.code;

    assert_take_after_poll_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(poll_i));
    assert_code_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (code_o == '0));
    assert_no_hvdec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (code_o != CODE_W'(SRC_HVDEC)) && (code_o < CODE_W'(NSRC)));
    assert_crit_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && code_o == CODE_W'(SRC_CRIT)) |-> $past(crit_en_i));
    assert_ext_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && code_o >= CODE_W'(SRC_WDOG)) |-> $past(ext_en_i));
    assert_sysrst_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && code_o != CODE_W'(SRC_SYSRST)) |-> !$past(pend[SRC_SYSRST]));
    assert_one_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take_clr));

endmodule

// File: tb/irq_prio_sel_tb.sv
`timescale 1ns/1ps
module irq_prio_sel_tb;
    import irqsel_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              poll_i = 1'b0;
    logic [NSRC-1:0]   set_i = '0;
    logic [NSRC-1:0]   clr_i = '0;
    logic              crit_en_i = 1'b0;
    logic              ext_en_i = 1'b0;
    logic              take_o;
    logic [CODE_W-1:0] code_o;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    logic        exp_take_q[$];
    int          exp_code_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    irq_prio_sel u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .poll_i    (poll_i),
        .set_i     (set_i),
        .clr_i     (clr_i),
        .crit_en_i (crit_en_i),
        .ext_en_i  (ext_en_i),
        .take_o    (take_o),
        .code_o    (code_o)
    );

    // monitor: compare one expected item per clock, 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (tag_q.size() > 0) begin
            logic  et;
            int    ec;
            string tg;
            et = exp_take_q.pop_front();
            ec = exp_code_q.pop_front();
            tg = tag_q.pop_front();
            vectors++;
            if (take_o !== et || int'(code_o) != ec) begin
                fails++;
                $display("FAIL %s: take=%0b code=%0d expected take=%0b code=%0d",
                         tg, take_o, code_o, et, ec);
            end
        end
    end

    // driver: one cycle of stimulus plus its expected result
    task automatic step(input logic poll, input logic [NSRC-1:0] s,
                        input logic [NSRC-1:0] c, input logic ce, input logic ee,
                        input logic et, input int ec, input string tg);
        @(negedge clk);
        poll_i = poll; set_i = s; clr_i = c; crit_en_i = ce; ext_en_i = ee;
        exp_take_q.push_back(et);
        exp_code_q.push_back(ec);
        tag_q.push_back(tg);
    endtask

    task automatic raise(input logic [NSRC-1:0] s, input string tg);
        step(1'b0, s, '0, 1'b0, 1'b0, 1'b0, 0, tg);
    endtask

    task automatic poll(input logic ce, input logic ee, input logic et,
                        input int ec, input string tg);
        step(1'b1, '0, '0, ce, ee, et, ec, tg);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        vectors++;
        if (take_o !== 1'b0 || code_o !== '0) begin
            fails++;
            $display("FAIL R1: take=%0b code=%0d expected take=0 code=0", take_o, code_o);
        end
        poll(1'b1, 1'b1, 1'b0, 0, "R1 nothing pending after reset");

        // every source pending at once
        raise({NSRC{1'b1}}, "R10 no take without poll");
        poll(1'b0, 1'b0, 1'b1, 0, "R2 system reset first, enables off");
        poll(1'b0, 1'b0, 1'b1, 1, "R2 machine check next");
        poll(1'b0, 1'b0, 1'b0, 0, "R7 tied source not taken, enables off");
        poll(1'b1, 1'b0, 1'b1, 3, "R3 critical with enable");
        poll(1'b1, 1'b0, 1'b1, 3, "R3 critical stays pending");
        poll(1'b0, 1'b1, 1'b1, 4, "R4 watchdog first in group");
        poll(1'b0, 1'b1, 1'b1, 5, "R4 critical doorbell");
        poll(1'b0, 1'b1, 1'b1, 6, "R4 fixed-interval timer");
        poll(1'b0, 1'b1, 1'b1, 7, "R4 programmable timer");
        poll(1'b0, 1'b1, 1'b1, 8, "R5 decrementer cleared on take");
        poll(1'b0, 1'b1, 1'b1, 9, "R5 external input");
        poll(1'b0, 1'b1, 1'b1, 9, "R5 external input not cleared");
        step(1'b0, '0, 13'(1 << 9), 1'b0, 1'b1, 1'b0, 0, "R9 clear pulse cycle");
        poll(1'b0, 1'b1, 1'b1, 10, "R9 external input gone, doorbell");
        poll(1'b0, 1'b1, 1'b1, 11, "R6 performance monitor");
        poll(1'b0, 1'b1, 1'b1, 12, "R6 thermal");
        poll(1'b0, 1'b1, 1'b0, 0, "R7 only tied source left");
        poll(1'b1, 1'b1, 1'b1, 3, "R3 critical still pending");
        step(1'b0, '0, 13'(1 << 3), 1'b1, 1'b1, 1'b0, 0, "R9 clear critical");
        poll(1'b1, 1'b1, 1'b0, 0, "R9 critical cleared");

        // set wins over clear pulse and over take
        step(1'b0, 13'(1 << 8), 13'(1 << 8), 1'b0, 1'b0, 1'b0, 0, "R8 set with clear");
        poll(1'b0, 1'b1, 1'b1, 8, "R8 set won over clear");
        raise(13'(1 << 8), "R8 raise decrementer");
        step(1'b1, 13'(1 << 8), '0, 1'b0, 1'b1, 1'b1, 8, "R8 take with set");
        poll(1'b0, 1'b1, 1'b1, 8, "R8 set won over take");
        poll(1'b0, 1'b1, 1'b0, 0, "R5 decrementer cleared");

        // gating and ordering with the tied source still pending
        raise(13'(1 << 6), "R4 raise fixed timer");
        poll(1'b1, 1'b0, 1'b0, 0, "R4 gated without external enable");
        poll(1'b0, 1'b1, 1'b1, 6, "R7 tied source does not block");
        raise(13'((1 << 1) | (1 << 12)), "R6 raise machine check and thermal");
        poll(1'b0, 1'b1, 1'b1, 1, "R6 machine check over thermal");
        poll(1'b0, 1'b1, 1'b1, 12, "R6 thermal after");
        raise(13'(1 << 7), "R10 raise programmable timer");
        step(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, 0, "R10 pending but no poll");
        poll(1'b0, 1'b1, 1'b1, 7, "R10 taken on poll");
        poll(1'b1, 1'b1, 1'b0, 0, "R10 nothing eligible");

        @(negedge clk);
        poll_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        summary();
    end

endmodule